// File: doc/BRIEF.md
# ADC Conversion Sequencer with Register Interface

This block sits on a simple register bus and runs single conversions for a successive-approximation converter with up to eight inputs. Software picks an input through a channel register and sets the conversion clock divider, enable, standby and resolution fields in a control word. It then sets the start bit in that same word. The block counts off a fixed number of conversion-clock periods, captures the chosen input, and stores it as a 12-bit or 10-bit result. It then raises a level interrupt, which stays high until software writes the clear register.

The analog converter is modelled as one digital sample port per channel. The selected sample is captured on the clock edge that ends the conversion. A delay register holds a 16-bit value for a later measurement sequencer and has no effect inside this block. Read data is registered and appears one cycle after the read strobe. Typical bring-up writes a prescaler value of 49, with the prescaler enabled and 12-bit resolution selected.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, the control, delay, channel and result registers all read 0 and `irqDone` is low.
- R2: The control word is at offset 0x00 and has these fields: bit 0 start, bit 2 standby, bits 13:6 prescaler value, bit 14 prescaler enable and bit 16 high resolution. Bits 2, 6 to 14 and 16 read back as written. Bit 0 and every other bit read as 0.
- R3: The delay register at offset 0x08 stores and returns the low 16 bits of the written data, with the upper bits reading 0.
- R4: The channel register at offset 0x1C stores the low 3 bits of the written data and returns them, with the other bits reading 0.
- R5: A start is accepted on the clock edge that samples the control write. `irqDone` goes high exactly 13×(P+1) cycles after that edge when the write has the prescaler enabled with value P, and exactly 13 cycles after it when the prescaler is disabled.
- R6: In high-resolution mode, the result register at offset 0x0C returns the 12-bit sample of the channel that was selected when the conversion started, taken at the edge that ends the conversion. The result changes at no other time.
- R7: When bit 16 was 0 at start, the result is the upper 10 bits of the sample, right-aligned (sample >> 2).
- R8: A start write is ignored while a conversion is busy, and it is also ignored when the same write sets the standby bit. An ignored start changes neither the completion time nor the result.
- R9: `irqDone` stays high after a conversion ends until any write to offset 0x18, after which it is low.
- R10: If a write to 0x18 lands on the same edge that ends a conversion, `irqDone` is high after that edge.
- R11: `busRdata` changes only on the edge after a cycle with `busRd` high. Offsets 0x18 and all unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the access |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, data valid the following cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| sampleBus | input | 96 | Eight 12-bit channel samples, channel n at bits 12n+11:12n |
| irqDone | output | 1 | Conversion-done interrupt, level |

## Verification
The assertions assume that `busWr` and `busRd` are never high in the same cycle. They also assume that the selected channel sample is stable across the edge that ends a conversion. The bench drives every access from a task that raises exactly one strobe for one cycle. It changes the sample inputs only while no conversion is running, and it holds each sample constant until the result has been read.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

  // Bus offsets decoded by the block
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_DELAY = 8'h08;
  localparam logic [7:0] OFF_DATA  = 8'h0C;
  localparam logic [7:0] OFF_CLR   = 8'h18;
  localparam logic [7:0] OFF_CHAN  = 8'h1C;

  // Control word field positions
  localparam int BIT_START   = 0;
  localparam int BIT_STANDBY = 2;
  localparam int PRE_LSB     = 6;
  localparam int PRE_W       = 8;
  localparam int BIT_PRE_EN  = 14;
  localparam int BIT_HIRES   = 16;

  localparam int CHSEL_W = 3;

  // Strobes from the register side to the conversion path
  typedef struct packed {
    logic               go;
    logic [PRE_W-1:0]   divLimit;
    logic [CHSEL_W-1:0] chan;
    logic               hiRes;
  } convCmd_t;

endpackage

// File: rtl/adc_conv_path.sv
module adc_conv_path
  import adcc_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int SMP_W      = 12,
  parameter int LOW_W      = 10,
  parameter int CONV_TICKS = 13
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  convCmd_t                cmd,
  input  logic [NUM_CH*SMP_W-1:0] sampleBus,
  output logic                    busy,
  output logic                    convDone,
  output logic [SMP_W-1:0]        result
);

  localparam int TICK_W = $clog2(CONV_TICKS + 1);
  localparam int SHIFT  = SMP_W - LOW_W;

  logic               busyQ;
  logic [PRE_W-1:0]   divCnt;
  logic [PRE_W-1:0]   divLimQ;
  logic [TICK_W-1:0]  tickCnt;
  logic [CHSEL_W-1:0] chanQ;
  logic               hiResQ;
  logic [SMP_W-1:0]   resultQ;

  logic [SMP_W-1:0]   chanSample [NUM_CH];
  logic [SMP_W-1:0]   picked;
  logic [SMP_W-1:0]   shaped;
  logic               tick;
  logic               lastTick;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_unpack
      assign chanSample[g] = sampleBus[g*SMP_W +: SMP_W];
    end
  endgenerate

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chanQ == CHSEL_W'(i)) picked = chanSample[i];
    end
  end

  assign shaped   = hiResQ ? picked : (picked >> SHIFT);
  assign tick     = busyQ && (divCnt == divLimQ);
  assign lastTick = tick && (tickCnt == TICK_W'(CONV_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      divCnt  <= '0;
      divLimQ <= '0;
      tickCnt <= '0;
      chanQ   <= '0;
      hiResQ  <= 1'b0;
      resultQ <= '0;
    end else if (cmd.go && !busyQ) begin
      busyQ   <= 1'b1;
      divCnt  <= '0;
      tickCnt <= '0;
      divLimQ <= cmd.divLimit;
      chanQ   <= cmd.chan;
      hiResQ  <= cmd.hiRes;
    end else if (busyQ) begin
      if (tick) begin
        divCnt <= '0;
        if (lastTick) begin
          busyQ   <= 1'b0;
          tickCnt <= '0;
          resultQ <= shaped;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign busy     = busyQ;
  assign convDone = lastTick;
  assign result   = resultQ;

  // R5
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < TICK_W'(CONV_TICKS));

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastTick) |=> (busyQ && tickCnt >= $past(tickCnt)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lastTick |=> $stable(resultQ));

endmodule

// File: rtl/adc_conv_regs.sv
module adc_conv_regs
  import adcc_pkg::*;
#(
  parameter int DLY_W  = 16,
  parameter int SMP_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              busy,
  input  logic              convDone,
  input  logic [SMP_W-1:0]  result,
  output convCmd_t          cmd,
  output logic              irqDone
);

  logic               standbyQ;
  logic [PRE_W-1:0]   preValQ;
  logic               preEnQ;
  logic               hiResQ;
  logic [DLY_W-1:0]   delayQ;
  logic [CHSEL_W-1:0] chanQ;
  logic               irqQ;
  logic [DATA_W-1:0]  rdataQ;
  logic [DATA_W-1:0]  rdNext;

  logic ctrlWr, delayWr, chanWr, clrWr;
  logic wrStandby, wrPreEn;
  logic [PRE_W-1:0] wrPreVal;

  assign ctrlWr  = busWr && (busAddr == OFF_CTRL);
  assign delayWr = busWr && (busAddr == OFF_DELAY);
  assign chanWr  = busWr && (busAddr == OFF_CHAN);
  assign clrWr   = busWr && (busAddr == OFF_CLR);

  assign wrStandby = busWdata[BIT_STANDBY];
  assign wrPreEn   = busWdata[BIT_PRE_EN];
  assign wrPreVal  = busWdata[PRE_LSB +: PRE_W];

  // Start command follows the fields of the same write
  always_comb begin
    cmd.go       = ctrlWr && busWdata[BIT_START] && !wrStandby && !busy;
    cmd.divLimit = wrPreEn ? wrPreVal : '0;
    cmd.chan     = chanQ;
    cmd.hiRes    = busWdata[BIT_HIRES];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      standbyQ <= 1'b0;
      preValQ  <= '0;
      preEnQ   <= 1'b0;
      hiResQ   <= 1'b0;
      delayQ   <= '0;
      chanQ    <= '0;
    end else begin
      if (ctrlWr) begin
        standbyQ <= wrStandby;
        preValQ  <= wrPreVal;
        preEnQ   <= wrPreEn;
        hiResQ   <= busWdata[BIT_HIRES];
      end
      if (delayWr) delayQ <= busWdata[DLY_W-1:0];
      if (chanWr)  chanQ  <= busWdata[CHSEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         irqQ <= 1'b0;
    else if (convDone) irqQ <= 1'b1;
    else if (clrWr)    irqQ <= 1'b0;
  end

  always_comb begin
    rdNext = '0;
    case (busAddr)
      OFF_CTRL: begin
        rdNext[BIT_STANDBY]         = standbyQ;
        rdNext[PRE_LSB +: PRE_W]    = preValQ;
        rdNext[BIT_PRE_EN]          = preEnQ;
        rdNext[BIT_HIRES]           = hiResQ;
      end
      OFF_DELAY: rdNext[DLY_W-1:0]   = delayQ;
      OFF_DATA:  rdNext[SMP_W-1:0]   = result;
      OFF_CHAN:  rdNext[CHSEL_W-1:0] = chanQ;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rdataQ <= '0;
    else if (busRd) rdataQ <= rdNext;
  end

  assign busRdata = rdataQ;
  assign irqDone  = irqQ;

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !convDone) |=> !irqDone);

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> irqDone);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));

  // R8
  standby_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrStandby) |=> !$rose(busy));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adcc_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int SMP_W      = 12,
  parameter int LOW_W      = 10,
  parameter int CONV_TICKS = 13,
  parameter int DLY_W      = 16,
  parameter int DATA_W     = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              busAddr,
  input  logic                    busWr,
  input  logic                    busRd,
  input  logic [DATA_W-1:0]       busWdata,
  output logic [DATA_W-1:0]       busRdata,
  input  logic [NUM_CH*SMP_W-1:0] sampleBus,
  output logic                    irqDone
);

  convCmd_t         cmd;
  logic             busy;
  logic             convDone;
  logic [SMP_W-1:0] result;

  adc_conv_regs #(
    .DLY_W (DLY_W),
    .SMP_W (SMP_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .busy    (busy),
    .convDone(convDone),
    .result  (result),
    .cmd     (cmd),
    .irqDone (irqDone)
  );

  adc_conv_path #(
    .NUM_CH    (NUM_CH),
    .SMP_W     (SMP_W),
    .LOW_W     (LOW_W),
    .CONV_TICKS(CONV_TICKS)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .sampleBus(sampleBus),
    .busy     (busy),
    .convDone (convDone),
    .result   (result)
  );

endmodule

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [95:0] sampleBus = '0;
  logic        irqDone;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_conv_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .sampleBus(sampleBus),
    .irqDone(irqDone)
  );

  function automatic int convCycles(input bit preEn, input int pv);
    return preEn ? 13 * (pv + 1) : 13;
  endfunction

  function automatic logic [31:0] expResult(input bit hiRes, input logic [11:0] s);
    return hiRes ? {20'd0, s} : {22'd0, s[11:2]};
  endfunction

  function automatic logic [31:0] ctrlWord(input bit start, input bit stby,
                                           input int pv, input bit preEn, input bit hiRes);
    logic [31:0] w;
    w = '0;
    w[0] = start; w[2] = stby; w[13:6] = pv[7:0]; w[14] = preEn; w[16] = hiRes;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic waitIrq(input int limit, output int took, input int c0);
    took = -1;
    for (int i = 0; i < limit; i++) begin
      if (irqDone) begin took = cyc - c0; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [11:0] smp [8];
    int c0, took, n;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irqDone}, 32'd0);
    busRead(8'h00, rd); check("R1 ctrl", rd, 32'd0);
    busRead(8'h08, rd); check("R1 delay", rd, 32'd0);
    busRead(8'h0C, rd); check("R1 data", rd, 32'd0);
    busRead(8'h1C, rd); check("R1 chan", rd, 32'd0);

    // R2 field readback (standby set, so start is blocked)
    busWrite(8'h00, 32'hFFFF_FFFF);
    busRead(8'h00, rd); check("R2 ctrl readback", rd, 32'h0001_7FC4);
    busWrite(8'h00, 32'h0);
    busRead(8'h00, rd); check("R2 ctrl cleared", rd, 32'd0);
    check("R8 standby start no irq", {31'd0, irqDone}, 32'd0);

    // R3, R4, R11
    busWrite(8'h08, 32'hABCD_1234);
    busRead(8'h08, rd); check("R3 delay", rd, 32'h0000_1234);
    busWrite(8'h1C, 32'hFFFF_FFFD);
    busRead(8'h1C, rd); check("R4 chan", rd, 32'd5);
    busRead(8'h04, rd); check("R11 unmapped", rd, 32'd0);
    busRead(8'h18, rd); check("R11 clear reads 0", rd, 32'd0);
    busAddr = 8'h08; repeat (2) @(negedge clk);
    check("R11 rdata held without strobe", busRdata, 32'd0);

    // R5 R6: directed, bring-up setting P=49 on channel 5
    for (int i = 0; i < 8; i++) sampleBus[i*12 +: 12] = 12'(12'h100 * i + 12'h0A5 + i);
    busWrite(8'h00, ctrlWord(1, 0, 49, 1, 1)); c0 = cyc;
    waitIrq(800, took, c0);
    check("R5 P=49 cycles", took, convCycles(1, 49));
    busRead(8'h0C, rd); check("R6 ch5 result", rd, expResult(1, 12'h5AA));

    // R9 level hold then clear
    repeat (5) @(negedge clk);
    check("R9 irq held", {31'd0, irqDone}, 32'd1);
    busWrite(8'h18, 32'h0);
    check("R9 irq cleared", {31'd0, irqDone}, 32'd0);

    // R8 standby blocks start, result unchanged
    busWrite(8'h00, ctrlWord(1, 1, 0, 0, 1));
    repeat (30) @(negedge clk);
    check("R8 standby no irq", {31'd0, irqDone}, 32'd0);
    busRead(8'h0C, rd); check("R8 standby result kept", rd, expResult(1, 12'h5AA));

    // R8 restart while busy ignored (prescaler 3, channel 2, 10-bit)
    busWrite(8'h1C, 32'd2);
    busWrite(8'h00, ctrlWord(1, 0, 3, 1, 0)); c0 = cyc;
    repeat (10) @(negedge clk);
    busWrite(8'h1C, 32'd7);
    busWrite(8'h00, ctrlWord(1, 0, 3, 1, 1));
    waitIrq(200, took, c0);
    check("R8 busy restart timing", took, convCycles(1, 3));
    busRead(8'h0C, rd); check("R7 R8 ch2 10-bit", rd, expResult(0, 12'h2A7));
    busWrite(8'h18, 32'h0);

    // R10 clear on the completion edge; prescaler disabled
    busWrite(8'h1C, 32'd0);
    busWrite(8'h00, ctrlWord(1, 0, 9, 0, 1)); c0 = cyc;
    n = convCycles(0, 9);
    while (cyc != c0 + n - 1) @(negedge clk);
    busWrite(8'h18, 32'h0);
    check("R10 done beats clear", {31'd0, irqDone}, 32'd1);
    busWrite(8'h18, 32'h0);
    check("R9 later clear", {31'd0, irqDone}, 32'd0);

    // Random conversions
    for (int it = 0; it < 24; it++) begin
      int ch, pv;
      bit pe, hr;
      ch = $urandom_range(7); pv = $urandom_range(15);
      pe = 1'($urandom_range(1)); hr = 1'($urandom_range(1));
      if (it == 0) begin ch = 7; pv = 0; pe = 1; hr = 0; end
      for (int k = 0; k < 8; k++) begin
        smp[k] = 12'($urandom_range(4095));
        sampleBus[k*12 +: 12] = smp[k];
      end
      if (it == 1) begin smp[ch] = 12'hFFF; sampleBus[ch*12 +: 12] = 12'hFFF; end
      busWrite(8'h1C, 32'(ch));
      busWrite(8'h00, ctrlWord(1, 0, pv, pe, hr)); c0 = cyc;
      waitIrq(400, took, c0);
      check("R5 random timing", took, convCycles(pe, pv));
      busRead(8'h0C, rd);
      check(hr ? "R6 random result" : "R7 random result", rd, expResult(hr, smp[ch]));
      busWrite(8'h18, 32'h0);
      check("R9 random clear", {31'd0, irqDone}, 32'd0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule